// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between a memory port and an instruction consumer and keeps a short byte queue filled ahead of execution. It builds a 20-bit physical byte address from a 16-bit code segment and a 16-bit fetch offset, using the formula (segment × 16 + offset) mod 2^20. It reads memory one aligned 16-bit word at a time over a request/grant port. A separate valid flag marks the returning data.

The consumer takes one byte per valid/ready handshake, in program order. A new word is requested only once the queue has room for two more bytes. Fetching overlaps with consumption, so the consumer rarely waits.

After a control transfer, the consumer pulses a flush together with a new segment:offset pair. The flush empties the queue, moves fetching to the new location, and drops the data of any word fetch that is still in flight. The queue depth is a parameter: six bytes by default, with a four-byte variant.

Top module: `instr_prefetch_queue`

## Requirements
- R1: After synchronous reset the queue is empty (`out_valid` low), and the first word request is for the word holding byte RST_SEG×16+RST_OFF. The first byte delivered is the byte at that address.
- R2: Every request address equals (segment×16 + offset) mod 2^20 with bit 0 forced to 0. The memory returns the even-address byte on `mem_rdata[7:0]` and the odd-address byte on `mem_rdata[15:8]`.
- R3: A request is started only when no other request is pending or outstanding and at least two queue slots are free. With QDEPTH=6, starting empty at an even offset and with no consumption, exactly 3 word fetches occur. Starting at an odd offset, 3 fetches occur, and one more follows after a single byte is consumed.
- R4: After an even-offset fetch the offset grows by 2, modulo 2^16. The segment changes only on flush, so a byte stream that crosses offset FFFFh continues at offset 0000h of the same segment.
- R5: When the fetch offset is odd, only the high byte (`mem_rdata[15:8]`) is queued and the offset grows by 1.
- R6: `mem_req` stays high with an unchanged `mem_addr` until the cycle `mem_gnt` is seen. After a grant no request is raised until `mem_rvalid` has returned that word. `mem_rvalid` is expected no earlier than the cycle after the grant.
- R7: A flush makes `out_valid` low in the next cycle. Fetching resumes at the new segment:offset. The data of a request that was granted, or was still waiting for a grant, when the flush came is discarded. A flush overrides a pop or a response in the same cycle.
- R8: `out_valid` is low exactly when the queue is empty. Each handshake delivers the next byte in program order, with no loss or duplication, including cycles where a word fills and a byte leaves at once.
- R9: With QDEPTH=4, starting empty at an even offset and with no consumption, exactly 2 word fetches occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the queue and redirect fetching |
| flush_seg | input | 16 | New code segment, taken with flush |
| flush_off | input | 16 | New fetch offset, taken with flush |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 20 | Physical byte address of the word, bit 0 zero |
| mem_gnt | input | 1 | Memory accepts the pending request |
| mem_rvalid | input | 1 | Read data of the granted request is valid |
| mem_rdata | input | 16 | Read word, low byte at the even address |
| out_valid | output | 1 | A byte is available to the consumer |
| out_byte | output | 8 | Byte at the head of the queue |
| out_ready | input | 1 | Consumer takes the head byte |

## Verification
Two pairs of functions can land in the same cycle. A returning word can be written into the queue in the same cycle that the consumer removes the head byte. A flush can coincide with a fetch that has been granted or is still waiting for a grant. The first pair is provoked by sweeping consumer ready duty cycles against several memory latencies and grant delays. The second is provoked by flushing while a long-latency response is pending, and while a request is being held without a grant. Both are judged by comparing every delivered byte with the byte expected at the running program address, and by counting word grants against the free-slot rule.

// File: rtl/ifq_pkg.sv
`timescale 1ns/1ps
package ifq_pkg;
    localparam int SEG_W  = 16;
    localparam int OFF_W  = 16;
    localparam int PA_W   = 20;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef logic [SEG_W-1:0]  seg_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PA_W-1:0]   paddr_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_REQ  = 2'd1,
        FS_WAIT = 2'd2
    } fstate_e;

    // bytes handed from the fetch side to the queue in one cycle
    typedef struct packed {
        logic [1:0] n;
        byte_t      first;
        byte_t      second;
    } fill_t;

    function automatic paddr_t phys_of(input seg_t s, input off_t o);
        return {s, 4'h0} + paddr_t'(o);
    endfunction

    function automatic paddr_t word_addr(input paddr_t a);
        return {a[PA_W-1:1], 1'b0};
    endfunction

    function automatic off_t off_step(input off_t o);
        return o + (o[0] ? off_t'(1) : off_t'(2));
    endfunction

    function automatic fill_t split_word(input word_t w, input logic odd_start);
        fill_t f;
        if (odd_start) begin
            f.n      = 2'd1;
            f.first  = w[15:8];
            f.second = '0;
        end else begin
            f.n      = 2'd2;
            f.first  = w[7:0];
            f.second = w[15:8];
        end
        return f;
    endfunction
endpackage

// File: rtl/ifq_ptr.sv
`timescale 1ns/1ps
module ifq_ptr
    import ifq_pkg::*;
#(
    parameter seg_t RST_SEG = 16'hFFFF,
    parameter off_t RST_OFF = 16'h0000
)(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  seg_t new_seg,
    input  off_t new_off,
    input  logic advance,
    output seg_t cur_seg,
    output off_t cur_off
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_seg <= RST_SEG;
            cur_off <= RST_OFF;
        end else if (flush) begin
            cur_seg <= new_seg;
            cur_off <= new_off;
        end else if (advance) begin
            cur_off <= off_step(cur_off);
        end
    end

    // segment moves only on redirect (R4)
    p_seg_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !flush |=> $stable(cur_seg));
endmodule

// File: rtl/ifq_fetch.sv
`timescale 1ns/1ps
module ifq_fetch
    import ifq_pkg::*;
#(
    parameter int CNT_W = 3
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [CNT_W-1:0] free,
    input  seg_t             cur_seg,
    input  off_t             cur_off,
    output logic             advance,
    output logic             mem_req,
    output paddr_t           mem_addr,
    input  logic             mem_gnt,
    input  logic             mem_rvalid,
    input  word_t            mem_rdata,
    output fill_t            fill
);
    fstate_e st;
    paddr_t  addr_q;
    logic    odd_q;
    logic    drop_q;
    logic    room;
    logic    issue;
    logic    take;

    assign room  = (free >= CNT_W'(2));
    assign issue = (st == FS_IDLE) && room && !flush;
    assign take  = (st == FS_WAIT) && mem_rvalid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= FS_IDLE;
            addr_q <= '0;
            odd_q  <= 1'b0;
            drop_q <= 1'b0;
        end else begin
            unique case (st)
                FS_IDLE: begin
                    if (issue) begin
                        st     <= FS_REQ;
                        addr_q <= word_addr(phys_of(cur_seg, cur_off));
                        odd_q  <= cur_off[0];
                        drop_q <= 1'b0;
                    end
                end
                FS_REQ: begin
                    if (mem_gnt) st <= FS_WAIT;
                    if (flush) drop_q <= 1'b1;
                end
                FS_WAIT: begin
                    if (mem_rvalid) begin
                        st     <= FS_IDLE;
                        drop_q <= 1'b0;
                    end else if (flush) begin
                        drop_q <= 1'b1;
                    end
                end
                default: st <= FS_IDLE;
            endcase
        end
    end

    assign mem_req  = (st == FS_REQ);
    assign mem_addr = addr_q;
    assign advance  = issue;

    always_comb begin
        fill = '0;
        if (take && !drop_q && !flush) fill = split_word(mem_rdata, odd_q);
    end

    // request held steady until granted (R6)
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
    // a request starts only with two free slots (R3)
    p_issue_space_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> ($past(free) >= CNT_W'(2)));
    // response closes the transfer before another request (R6)
    p_one_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
        take |=> !mem_req);
endmodule

// File: rtl/ifq_queue.sv
`timescale 1ns/1ps
module ifq_queue
    import ifq_pkg::*;
#(
    parameter  int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  fill_t            fill,
    input  logic             pop,
    output byte_t            head,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] free
);
    byte_t            slot_view [DEPTH];
    logic [IDX_W-1:0] rd_i;
    logic [IDX_W-1:0] wr_i;
    logic [IDX_W-1:0] wr_nx;
    logic [CNT_W-1:0] n_in;

    function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] i);
        return (i == IDX_W'(DEPTH - 1)) ? '0 : i + IDX_W'(1);
    endfunction

    assign wr_nx = bump(wr_i);
    assign n_in  = CNT_W'(fill.n);

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        byte_t slot_q;
        always_ff @(posedge clk) begin
            if (fill.n != 2'd0 && wr_i == IDX_W'(j))
                slot_q <= fill.first;
            else if (fill.n == 2'd2 && wr_nx == IDX_W'(j))
                slot_q <= fill.second;
        end
        assign slot_view[j] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rd_i  <= '0;
            wr_i  <= '0;
            count <= '0;
        end else begin
            if (fill.n == 2'd2)      wr_i <= bump(wr_nx);
            else if (fill.n == 2'd1) wr_i <= wr_nx;
            if (pop) rd_i <= bump(rd_i);
            count <= count + n_in - CNT_W'(pop);
        end
    end

    assign head = slot_view[rd_i];
    assign free = CNT_W'(DEPTH) - count;

    // a fill never exceeds the room left (R3)
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (CNT_W'(fill.n) <= free));
    // occupancy moves only on fill, pop or clear (R8)
    p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!clear && fill.n == 2'd0 && !pop) |=> $stable(count));
endmodule

// File: rtl/instr_prefetch_queue.sv
`timescale 1ns/1ps
module instr_prefetch_queue
    import ifq_pkg::*;
#(
    parameter int          QDEPTH  = 6,
    parameter logic [15:0] RST_SEG = 16'hFFFF,
    parameter logic [15:0] RST_OFF = 16'h0000
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic [15:0] flush_seg,
    input  logic [15:0] flush_off,
    output logic        mem_req,
    output logic [19:0] mem_addr,
    input  logic        mem_gnt,
    input  logic        mem_rvalid,
    input  logic [15:0] mem_rdata,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_byte
);
    localparam int CNT_W = $clog2(QDEPTH + 1);

    seg_t             cur_seg;
    off_t             cur_off;
    logic             advance;
    fill_t            fill;
    logic [CNT_W-1:0] q_count;
    logic [CNT_W-1:0] q_free;
    byte_t            head;
    logic             pop;

    assign out_valid = (q_count != '0);
    assign pop       = out_valid && out_ready && !flush;
    assign out_byte  = head;

    ifq_ptr #(
        .RST_SEG (RST_SEG),
        .RST_OFF (RST_OFF)
    ) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .new_seg (flush_seg),
        .new_off (flush_off),
        .advance (advance),
        .cur_seg (cur_seg),
        .cur_off (cur_off)
    );

    ifq_fetch #(
        .CNT_W (CNT_W)
    ) u_fetch (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .free       (q_free),
        .cur_seg    (cur_seg),
        .cur_off    (cur_off),
        .advance    (advance),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .mem_gnt    (mem_gnt),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .fill       (fill)
    );

    ifq_queue #(
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk   (clk),
        .rst   (rst),
        .clear (flush),
        .fill  (fill),
        .pop   (pop),
        .head  (head),
        .count (q_count),
        .free  (q_free)
    );

    // redirect empties the queue (R7)
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> !out_valid);
    // a kept fill is visible to the consumer next cycle (R8)
    p_fill_visible_r8: assert property (@(posedge clk) disable iff (rst)
        (fill.n != 2'd0 && !flush) |=> out_valid);
endmodule

// File: tb/tb_instr_prefetch_queue.sv
`timescale 1ns/1ps
module tb_instr_prefetch_queue;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst, flush, out_ready;
    logic [15:0] flush_seg, flush_off;
    logic        mem_req, mem_gnt, mem_rvalid, out_valid;
    logic [19:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [7:0]  out_byte;

    logic        mem4_req, mem4_gnt, mem4_rvalid, out4_valid, out4_ready;
    logic [19:0] mem4_addr;
    logic [15:0] mem4_rdata;
    logic [7:0]  out4_byte;

    instr_prefetch_queue #(.QDEPTH(6), .RST_SEG(16'hF000), .RST_OFF(16'hFFFA)) dut (
        .clk(clk), .rst(rst), .flush(flush), .flush_seg(flush_seg), .flush_off(flush_off),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte));

    instr_prefetch_queue #(.QDEPTH(4), .RST_SEG(16'h0800), .RST_OFF(16'h0000)) dut4 (
        .clk(clk), .rst(rst), .flush(1'b0), .flush_seg(16'h0), .flush_off(16'h0),
        .mem_req(mem4_req), .mem_addr(mem4_addr), .mem_gnt(mem4_gnt), .mem_rvalid(mem4_rvalid),
        .mem_rdata(mem4_rdata), .out_valid(out4_valid), .out_ready(out4_ready), .out_byte(out4_byte));

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // seg, off, bytes, ready period, latency, grant wait
    localparam logic [63:0] VEC [6] = '{
        64'hF000_0000_0C01_0000,
        64'h1234_0005_0902_0200,
        64'hFFFF_0010_0801_0100,
        64'h0100_FFFD_0A01_0000,
        64'hABCD_7FFE_1003_0301,
        64'h0000_0000_0701_0002
    };

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        int a;
        a = (int'(s) * 16 + int'(o)) % 1048576;
        return a[19:0];
    endfunction

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return (a[7:0] * 8'd5) ^ a[15:8] ^ {a[19:16], 4'hA};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // memory model for the main instance
    int          gnt_wait = 0, lat = 0, wait_cnt = 0, resp_cnt = 0, grants = 0, stalls = 0;
    bit          resp_pend = 0, chk_addr_en = 1, skip_one = 0;
    logic [19:0] resp_addr = '0, prev_addr = '0;
    bit          prev_req = 0, prev_gnt = 0;
    logic [15:0] exp_seg = 16'hF000, exp_off = 16'hFFFA;

    initial begin
        mem_gnt = 0; mem_rvalid = 0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (prev_req && !prev_gnt)
                    chk(mem_req && mem_addr == prev_addr, "R6", "request held stable",
                        {11'b0, mem_req, mem_addr}, {12'h001, prev_addr});
                if (resp_pend)
                    chk(!mem_req, "R6", "no request while outstanding", mem_req, 0);
            end
            mem_rvalid = 0;
            if (resp_pend) begin
                if (resp_cnt == 0) begin
                    mem_rvalid = 1;
                    mem_rdata  = {mbyte(resp_addr | 20'h1), mbyte(resp_addr)};
                    resp_pend  = 0;
                end else resp_cnt--;
            end
            mem_gnt = 0;
            if (mem_req && !rst) begin
                if (wait_cnt >= gnt_wait) begin
                    mem_gnt = 1; wait_cnt = 0; grants++;
                    resp_pend = 1; resp_addr = mem_addr; resp_cnt = lat;
                    if (skip_one) skip_one = 0;
                    else if (chk_addr_en) begin
                        chk(mem_addr == {phys(exp_seg, exp_off)[19:1], 1'b0}, "R2",
                            "request address", mem_addr, {phys(exp_seg, exp_off)[19:1], 1'b0});
                        exp_off = exp_off + (exp_off[0] ? 16'd1 : 16'd2);
                    end
                end else begin
                    wait_cnt++; stalls++;
                end
            end else wait_cnt = 0;
            prev_req = mem_req; prev_gnt = mem_gnt; prev_addr = mem_addr;
        end
    end

    // memory model for the four-deep instance: grant at once, data next cycle
    int          grants4 = 0;
    bit          pend4 = 0;
    logic [19:0] addr4 = '0;
    initial begin
        mem4_gnt = 0; mem4_rvalid = 0; mem4_rdata = '0;
        forever begin
            @(negedge clk);
            mem4_rvalid = 0;
            if (pend4) begin
                mem4_rvalid = 1;
                mem4_rdata  = {mbyte(addr4 | 20'h1), mbyte(addr4)};
                pend4 = 0;
            end
            mem4_gnt = 0;
            if (mem4_req && !rst) begin
                mem4_gnt = 1; pend4 = 1; addr4 = mem4_addr; grants4++;
            end
        end
    end

    task automatic consume(input logic [15:0] s, input logic [15:0] o, input int n,
                           input int pat, input string tag);
        int got = 0;
        int cyc = 0;
        logic [15:0] k = o;
        while (got < n && cyc < 4000) begin
            @(negedge clk);
            out_ready = ((cyc % pat) == 0);
            if (out_ready && out_valid) begin
                chk(out_byte == mbyte(phys(s, k)), tag, "stream byte", out_byte, mbyte(phys(s, k)));
                k = k + 16'd1;
                got++;
            end
            cyc++;
        end
        chk(got == n, tag, "bytes delivered", got, n);
        @(negedge clk);
        out_ready = 0;
    endtask

    task automatic flush_now(input logic [15:0] s, input logic [15:0] o);
        flush = 1; flush_seg = s; flush_off = o;
        exp_seg = s; exp_off = o;
        @(negedge clk);
        flush = 0;
    endtask

    task automatic flush_idle(input logic [15:0] s, input logic [15:0] o);
        @(negedge clk);
        while (mem_req) @(negedge clk);
        flush_now(s, o);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog (R8): actual cycles 150000 expected fewer");
        finish_run();
    end

    initial begin
        int g0;
        rst = 1; flush = 0; flush_seg = '0; flush_off = '0; out_ready = 0; out4_ready = 0;
        repeat (4) @(negedge clk);
        rst = 0;
        // R1: empty after reset, stream starts at reset location
        chk(!out_valid, "R1", "out_valid after reset", out_valid, 0);
        chk(!out4_valid, "R1", "out_valid after reset (depth 4)", out4_valid, 0);
        consume(16'hF000, 16'hFFFA, 10, 1, "R1/R4 reset stream across offset wrap");

        // table of vectors: R2 R4 R5 R8 under varied patterns
        for (int i = 0; i < 6; i++) begin
            lat = int'(VEC[i][15:8]); gnt_wait = int'(VEC[i][7:0]);
            flush_idle(VEC[i][63:48], VEC[i][47:32]);
            consume(VEC[i][63:48], VEC[i][47:32], int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                    "R2/R4/R5/R8 vector stream");
        end

        // R3: refill stops at two free slots, even start
        lat = 0; gnt_wait = 0;
        flush_idle(16'h2000, 16'h0100);
        g0 = grants;
        repeat (30) @(negedge clk);
        chk(grants - g0 == 3, "R3", "word fetches from even start", grants - g0, 3);
        chk(!mem_req && out_valid, "R3", "idle with full queue", {mem_req, out_valid}, 2'b01);

        // R3/R5: odd start takes one byte first
        flush_idle(16'h2000, 16'h0101);
        g0 = grants;
        repeat (30) @(negedge clk);
        chk(grants - g0 == 3, "R3", "word fetches from odd start", grants - g0, 3);
        consume(16'h2000, 16'h0101, 1, 1, "R5 high byte first");
        repeat (20) @(negedge clk);
        chk(grants - g0 == 4, "R3", "refill after one pop", grants - g0, 4);
        consume(16'h2000, 16'h0102, 10, 1, "R5/R8 continue after realign");

        // R6: grant stalls
        gnt_wait = 6; lat = 2;
        flush_idle(16'h3300, 16'h0020);
        g0 = stalls;
        consume(16'h3300, 16'h0020, 8, 2, "R6 stream under grant stall");
        chk(stalls > g0, "R6", "held request observed", stalls - g0, 1);

        // R7: flush with full queue, then flush with response in flight
        gnt_wait = 0; lat = 0;
        flush_idle(16'h3000, 16'h0000);
        repeat (20) @(negedge clk);
        chk(out_valid, "R7", "queue filled before flush", out_valid, 1);
        flush_now(16'h3100, 16'h0004);
        chk(!out_valid, "R7", "out_valid after flush", out_valid, 0);
        consume(16'h3100, 16'h0004, 4, 1, "R7 stream after flush");
        lat = 8;
        flush_idle(16'h3200, 16'h0000);
        while (!resp_pend) @(negedge clk);
        flush_now(16'h4000, 16'h0011);
        chk(!out_valid, "R7", "empty with response in flight", out_valid, 0);
        consume(16'h4000, 16'h0011, 8, 1, "R7 in-flight data discarded");

        // R7: flush while a request waits for its grant
        gnt_wait = 10; lat = 1;
        flush_idle(16'h5000, 16'h0040);
        while (!mem_req) @(negedge clk);
        skip_one = 1;
        flush_now(16'h6000, 16'h0080);
        consume(16'h6000, 16'h0080, 8, 1, "R7 ungranted request discarded");

        // R9: four-deep instance takes exactly two words
        chk(grants4 == 2, "R9", "word fetches with depth 4", grants4, 2);
        chk(!mem4_req && out4_valid, "R9", "idle with full depth-4 queue",
            {mem4_req, out4_valid}, 2'b01);
        for (int k = 0; k < 4; k++) begin
            chk(out4_valid && out4_byte == mbyte(phys(16'h0800, 16'(k))), "R9", "depth-4 byte",
                out4_byte, mbyte(phys(16'h0800, 16'(k))));
            out4_ready = 1;
            @(negedge clk);
            out4_ready = 0;
            @(negedge clk);
        end

        finish_run();
    end
endmodule